// File: doc/BRIEF.md
# Legacy Video Window Address Decoder

This block classifies a memory request address against the 128 KB legacy video window and picks which downstream target should claim it. The window is split into three sub-ranges: a 64 KB graphics area at 0x000A_0000–0x000A_FFFF, a 32 KB monochrome-adapter area at 0x000B_0000–0x000B_7FFF, and a 32 KB text area at 0x000B_8000–0x000B_FFFF. Two steering bits decide the target of each sub-range. One bit enables video steering to the internal PCI Express device. The other says a monochrome adapter sits on the default downstream port.

The internal PCI Express device is always tried first. It claims any window address that the steering bits give it. Every other window address falls to the default downstream port. Addresses outside the window get the "no target" code. Separately, the block flags main-memory hits, from 16 MB up to a programmable top-of-low-memory value, with that value excluded. The decode result is captured in a register when the address strobe is high, so it appears one clock after the address.

Top module: `legacy_vga_decode`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is 0, `target_o` is 0 (no target), `region_o` is 0 and `main_hit_o` is 0, until the first accepted address.
- R2: `valid_o` is 1 exactly in the cycle after a cycle with `addr_valid_i` high, and 0 otherwise. In that cycle, `target_o`, `region_o` and `main_hit_o` describe the address presented one cycle earlier.
- R3: While `addr_valid_i` is low, `target_o`, `region_o` and `main_hit_o` keep their last values, whatever the address and configuration inputs do.
- R4: With `vga_en_i` = 1, addresses in the graphics sub-range (0x000A_0000–0x000A_FFFF) and the text sub-range (0x000B_8000–0x000B_FFFF) give `target_o` = 1 (internal PCI Express device).
- R5: With `vga_en_i` = 1, an address in the monochrome sub-range (0x000B_0000–0x000B_7FFF) gives `target_o` = 1 when `mono_present_i` = 0, and `target_o` = 2 (default downstream port) when `mono_present_i` = 1.
- R6: With `vga_en_i` = 0, every address in the three sub-ranges gives `target_o` = 2, whatever the value of `mono_present_i`.
- R7: An address outside 0x000A_0000–0x000B_FFFF gives `target_o` = 0, and so do the neighbours 0x0009_FFFF and 0x000C_0000. The upper address bits are fully decoded, so there is no aliasing.
- R8: `main_hit_o` is 1 exactly when 0x0100_0000 <= address < `tolud_i`. There is no hit at `tolud_i` itself, and no hit at all when `tolud_i` <= 0x0100_0000.
- R9: `region_o` encodes the sub-range hit: 0 outside the window, 1 for graphics, 2 for monochrome, 3 for text. It is 0 exactly when `target_o` is 0.
- R10: A main-memory hit never comes with a video target. When `main_hit_o` is 1, `target_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_valid_i | input | 1 | Address strobe; the decode is captured when high |
| addr_i | input | ADDR_W | Memory request address |
| vga_en_i | input | 1 | Steer the video window to the internal PCI Express device |
| mono_present_i | input | 1 | Monochrome adapter is on the default port |
| tolud_i | input | ADDR_W | Top of low memory; exclusive upper bound of main memory |
| valid_o | output | 1 | Registered decode result is new this cycle |
| target_o | output | 2 | 0 no target, 1 PCI Express device, 2 default port |
| region_o | output | 2 | 0 none, 1 graphics, 2 monochrome, 3 text |
| main_hit_o | output | 1 | Address lies in main memory |

## Verification
The bench builds the block with its defaults: a 32-bit address, the window based at 0x000A_0000 and main memory starting at 0x0100_0000. These values put every sub-range edge, the 16 MB floor and an arbitrary 32-bit top-of-low-memory within reach of directed stimulus. They also allow addresses that match the window in their low bits only, which exposes any partial decode of the upper bits.

// File: rtl/vga_dec_pkg.sv
package vga_dec_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PCIE = 2'd1,
    TGT_DFLT = 2'd2
  } target_e;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_GFX  = 2'd1,
    REG_MONO = 2'd2,
    REG_TEXT = 2'd3
  } region_e;

  localparam int unsigned NUM_SUB = 3;

endpackage

// File: rtl/vga_rst_sync.sv
module vga_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vga_window_classify.sv
module vga_window_classify
  import vga_dec_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VGA_BASE = 32'h000A_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);

  localparam int unsigned GFX_SZ  = 32'h1_0000;
  localparam int unsigned MONO_SZ = 32'h0_8000;
  localparam int unsigned TEXT_SZ = 32'h0_8000;

  logic [NUM_SUB-1:0] sub_hit;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    localparam int unsigned OFS  = (g == 0) ? 0 : ((g == 1) ? GFX_SZ : GFX_SZ + MONO_SZ);
    localparam int unsigned SZ   = (g == 0) ? GFX_SZ : ((g == 1) ? MONO_SZ : TEXT_SZ);
    localparam logic [ADDR_W-1:0] LO = VGA_BASE + ADDR_W'(OFS);
    localparam logic [ADDR_W-1:0] HI = VGA_BASE + ADDR_W'(OFS + SZ - 1);
    assign sub_hit[g] = (addr_i >= LO) && (addr_i <= HI);
  end

  always_comb begin
    region_o = REG_NONE;
    if (sub_hit[0])      region_o = REG_GFX;
    else if (sub_hit[1]) region_o = REG_MONO;
    else if (sub_hit[2]) region_o = REG_TEXT;
  end

endmodule

// File: rtl/vga_steer.sv
module vga_steer
  import vga_dec_pkg::*;
(
  input  region_e region_i,
  input  logic    vga_en_i,
  input  logic    mono_present_i,
  output target_e target_o
);

  logic in_window;
  logic pcie_claim;

  assign in_window = (region_i != REG_NONE);

  always_comb begin
    pcie_claim = 1'b0;
    unique case (region_i)
      REG_GFX,
      REG_TEXT: pcie_claim = vga_en_i;
      REG_MONO: pcie_claim = vga_en_i && !mono_present_i;
      default:  pcie_claim = 1'b0;
    endcase
  end

  always_comb begin
    if (pcie_claim)     target_o = TGT_PCIE;
    else if (in_window) target_o = TGT_DFLT;
    else                target_o = TGT_NONE;
  end

endmodule

// File: rtl/main_mem_cmp.sv
module main_mem_cmp #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 32'h0100_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] tolud_i,
  output logic              hit_o
);

  logic above_floor;
  logic below_top;

  assign above_floor = (addr_i >= MAIN_BASE);
  assign below_top   = (addr_i < tolud_i);
  assign hit_o       = above_floor && below_top;

endmodule

// File: rtl/legacy_vga_decode.sv
module legacy_vga_decode
  import vga_dec_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] VGA_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 32'h0100_0000,
  parameter int unsigned       RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vga_en_i,
  input  logic              mono_present_i,
  input  logic [ADDR_W-1:0] tolud_i,
  output logic              valid_o,
  output logic [1:0]        target_o,
  output logic [1:0]        region_o,
  output logic              main_hit_o
);

  logic    rst_core_n;
  region_e region_c;
  target_e target_c;
  logic    main_c;

  logic    valid_d,  valid_q;
  target_e target_d, target_q;
  region_e region_d, region_q;
  logic    main_d,   main_q;

  vga_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  vga_window_classify #(.ADDR_W(ADDR_W), .VGA_BASE(VGA_BASE)) u_classify (
    .addr_i   (addr_i),
    .region_o (region_c)
  );

  vga_steer u_steer (
    .region_i       (region_c),
    .vga_en_i       (vga_en_i),
    .mono_present_i (mono_present_i),
    .target_o       (target_c)
  );

  main_mem_cmp #(.ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE)) u_main (
    .addr_i  (addr_i),
    .tolud_i (tolud_i),
    .hit_o   (main_c)
  );

  // Next state: capture only on the address strobe, otherwise hold.
  always_comb begin
    valid_d  = addr_valid_i;
    target_d = target_q;
    region_d = region_q;
    main_d   = main_q;
    if (addr_valid_i) begin
      target_d = target_c;
      region_d = region_c;
      main_d   = main_c;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q  <= 1'b0;
      target_q <= TGT_NONE;
      region_q <= REG_NONE;
      main_q   <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      target_q <= target_d;
      region_q <= region_d;
      main_q   <= main_d;
    end
  end

  assign valid_o    = valid_q;
  assign target_o   = target_q;
  assign region_o   = region_q;
  assign main_hit_o = main_q;

endmodule

// File: rtl/legacy_vga_decode_chk.sv
module legacy_vga_decode_chk #(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VGA_BASE = 32'h000A_0000
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              addr_valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              vga_en_i,
  input logic              mono_present_i,
  input logic              valid_o,
  input logic [1:0]        target_o,
  input logic [1:0]        region_o,
  input logic              main_hit_o
);

  localparam logic [ADDR_W-1:0] MONO_LO = VGA_BASE + ADDR_W'(32'h1_0000);
  localparam logic [ADDR_W-1:0] MONO_HI = VGA_BASE + ADDR_W'(32'h1_7FFF);
  localparam logic [ADDR_W-1:0] WIN_LO  = VGA_BASE;
  localparam logic [ADDR_W-1:0] WIN_HI  = VGA_BASE + ADDR_W'(32'h1_FFFF);

  logic in_mono, in_win;
  assign in_mono = (addr_i >= MONO_LO) && (addr_i <= MONO_HI);
  assign in_win  = (addr_i >= WIN_LO)  && (addr_i <= WIN_HI);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    addr_valid_i |=> valid_o);

  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !addr_valid_i |=> !valid_o);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !addr_valid_i |=> ($stable(target_o) && $stable(region_o) && $stable(main_hit_o)));

  p_mono_steer_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr_valid_i && vga_en_i && mono_present_i && in_mono) |=> (target_o == 2'd2));

  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr_valid_i && !vga_en_i && in_win) |=> (target_o == 2'd2));

  p_outside_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (addr_valid_i && !in_win) |=> (target_o == 2'd0));

  p_region_match_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (region_o == 2'd0) == (target_o == 2'd0));

  p_main_excl_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    main_hit_o |-> (target_o == 2'd0));

  p_target_legal_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    target_o != 2'd3);

endmodule

bind legacy_vga_decode legacy_vga_decode_chk #(
  .ADDR_W   (ADDR_W),
  .VGA_BASE (VGA_BASE)
) u_chk (
  .clk            (clk),
  .rst_core_n     (rst_core_n),
  .addr_valid_i   (addr_valid_i),
  .addr_i         (addr_i),
  .vga_en_i       (vga_en_i),
  .mono_present_i (mono_present_i),
  .valid_o        (valid_o),
  .target_o       (target_o),
  .region_o       (region_o),
  .main_hit_o     (main_hit_o)
);

// File: tb/legacy_vga_decode_tb.sv
module legacy_vga_decode_tb;

  localparam int unsigned ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              addr_valid_i;
  logic [ADDR_W-1:0] addr_i;
  logic              vga_en_i;
  logic              mono_present_i;
  logic [ADDR_W-1:0] tolud_i;
  logic              valid_o;
  logic [1:0]        target_o;
  logic [1:0]        region_o;
  logic              main_hit_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  legacy_vga_decode u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_valid_i   (addr_valid_i),
    .addr_i         (addr_i),
    .vga_en_i       (vga_en_i),
    .mono_present_i (mono_present_i),
    .tolud_i        (tolud_i),
    .valid_o        (valid_o),
    .target_o       (target_o),
    .region_o       (region_o),
    .main_hit_o     (main_hit_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive one address for one cycle; on return the registered result is visible.
  task automatic present(input logic [31:0] a, input logic en, input logic mono,
                         input logic [31:0] top);
    @(negedge clk);
    addr_i = a; vga_en_i = en; mono_present_i = mono; tolud_i = top;
    addr_valid_i = 1'b1;
    @(negedge clk);
    addr_valid_i = 1'b0;
  endtask

  task automatic expect_dec(input string req, input logic [31:0] a, input logic en,
                            input logic mono, input logic [1:0] tgt, input logic [1:0] reg_c);
    present(a, en, mono, 32'h0);
    check(req, $sformatf("target @0x%0h", a), {30'd0, target_o}, {30'd0, tgt});
    check(req, $sformatf("region @0x%0h", a), {30'd0, region_o}, {30'd0, reg_c});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "valid in reset",  {31'd0, valid_o},    32'd0);
    check("R1", "target in reset", {30'd0, target_o},   32'd0);
    check("R1", "region in reset", {30'd0, region_o},   32'd0);
    check("R1", "main in reset",   {31'd0, main_hit_o}, 32'd0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    addr_i = 32'h000A_1234; vga_en_i = 1'b1; mono_present_i = 1'b0; addr_valid_i = 1'b1;
    @(negedge clk);
    addr_valid_i = 1'b0;
    check("R2", "valid one cycle later", {31'd0, valid_o}, 32'd1);
    check("R2", "target with valid",     {30'd0, target_o}, 32'd1);
    @(negedge clk);
    check("R2", "valid drops",           {31'd0, valid_o}, 32'd0);
  endtask

  task automatic t_hold();
    present(32'h000B_9000, 1'b1, 1'b0, 32'h0);
    addr_i = 32'h0200_0000; vga_en_i = 1'b0; tolud_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R3", "target held", {30'd0, target_o},   32'd1);
    check("R3", "region held", {30'd0, region_o},   32'd3);
    check("R3", "main held",   {31'd0, main_hit_o}, 32'd0);
  endtask

  task automatic t_enabled();
    expect_dec("R4", 32'h000A_0000, 1'b1, 1'b0, 2'd1, 2'd1);
    expect_dec("R4", 32'h000A_FFFF, 1'b1, 1'b1, 2'd1, 2'd1);
    expect_dec("R4", 32'h000B_8000, 1'b1, 1'b1, 2'd1, 2'd3);
    expect_dec("R4", 32'h000B_FFFF, 1'b1, 1'b0, 2'd1, 2'd3);
  endtask

  task automatic t_mono();
    expect_dec("R5", 32'h000B_0000, 1'b1, 1'b0, 2'd1, 2'd2);
    expect_dec("R5", 32'h000B_7FFF, 1'b1, 1'b0, 2'd1, 2'd2);
    expect_dec("R5", 32'h000B_0000, 1'b1, 1'b1, 2'd2, 2'd2);
    expect_dec("R5", 32'h000B_7FFF, 1'b1, 1'b1, 2'd2, 2'd2);
  endtask

  task automatic t_disabled();
    for (int m = 0; m < 2; m++) begin
      expect_dec("R6", 32'h000A_8000, 1'b0, m[0], 2'd2, 2'd1);
      expect_dec("R6", 32'h000B_4000, 1'b0, m[0], 2'd2, 2'd2);
      expect_dec("R6", 32'h000B_C000, 1'b0, m[0], 2'd2, 2'd3);
    end
  endtask

  task automatic t_outside();
    expect_dec("R7", 32'h0009_FFFF, 1'b1, 1'b0, 2'd0, 2'd0);
    expect_dec("R7", 32'h000C_0000, 1'b1, 1'b0, 2'd0, 2'd0);
    expect_dec("R7", 32'h100A_0000, 1'b1, 1'b0, 2'd0, 2'd0);
    expect_dec("R7", 32'h800B_0000, 1'b0, 1'b1, 2'd0, 2'd0);
  endtask

  task automatic main_case(input logic [31:0] a, input logic [31:0] top, input logic exp);
    present(a, 1'b1, 1'b0, top);
    check("R8", $sformatf("main @0x%0h top 0x%0h", a, top), {31'd0, main_hit_o}, {31'd0, exp});
    check("R10", $sformatf("no video target @0x%0h", a), {30'd0, target_o}, 32'd0);
  endtask

  task automatic t_main();
    main_case(32'h00FF_FFFF, 32'h4000_0000, 1'b0);
    main_case(32'h0100_0000, 32'h4000_0000, 1'b1);
    main_case(32'h3FFF_FFFF, 32'h4000_0000, 1'b1);
    main_case(32'h4000_0000, 32'h4000_0000, 1'b0);
    main_case(32'h0100_0000, 32'h0100_0000, 1'b0);
    main_case(32'h0180_0000, 32'h0080_0000, 1'b0);
    present(32'h000A_0000, 1'b1, 1'b0, 32'hFFFF_FFFF);
    check("R8", "video address not main", {31'd0, main_hit_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; addr_valid_i = 1'b0; addr_i = '0;
    vga_en_i = 1'b0; mono_present_i = 1'b0; tolud_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latency();
    t_hold();
    t_enabled();
    t_mono();
    t_disabled();
    t_outside();
    t_main();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule